// File: doc/BRIEF.md
# BCD calendar timekeeping counter

This block is the timekeeping core of a real-time clock. It keeps seconds, minutes, hours, weekday, day of month, month and year. It counts enable pulses from a slow base clock, and each time a parameterised number of them has been counted it steps the time forward by one second. The step carries through the calendar: seconds, minutes, hours, weekday, day, month and a three-digit year. Month lengths and leap years follow the Gregorian rule.

Software sees every field in BCD through a field select. Writes are converted from BCD to binary and stored in the same cycle. Reads are converted back to BCD combinationally. Time writes take effect only while the run enable is high. While that enable is low the seconds prescaler is cleared, so raising the enable always starts a full second. A one-cycle strobe tells a downstream alarm comparator that a new second has just become readable.

The month is kept internally as 0 to 11 and is presented as BCD 1 to 12. The year field is 0 to 999. For the leap-year rule a parameterised base year is added to it; the default base of 1900 makes year field 100 the calendar year 2000.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read as seconds 0x00, minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 and year 0x000, and the second strobe is low.
- R2: While run_en is high, every TICKS_PER_SEC-th base_tick adds one second. The new value is readable in the cycle after the edge that counted that tick, and sec_strobe is high in exactly that one cycle. Dropping run_en clears the tick count, so after it rises again a full TICKS_PER_SEC ticks are needed.
- R3: Cycles with base_tick low are not counted toward the second, and no second passes while run_en is low.
- R4: Seconds wrap from 59 to 0 and carry into the minutes. Minutes wrap from 59 to 0 and carry into the hours. Hours wrap from 23 to 0.
- R5: At the hour wrap from 23 to 0, the weekday advances modulo 7 (6 goes to 0) and the day of month advances.
- R6: After a month's last day the day becomes 1 and the month advances. Months 4, 6, 9 and 11 have 30 days and the others 31. After December (0x12) comes January (0x01) with the year plus one, and year 999 wraps to 000.
- R7: February has 29 days when (year field + YEAR_BASE) is divisible by 4 and is either not divisible by 100 or divisible by 400; otherwise it has 28. With the default base, field 100 and field 104 are leap years, while 101 and 200 are not.
- R8: Field select codes are: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 weekday, 5 month, 6 year; code 7 reads 0. Reads are two-digit BCD in bits [7:0], and the month reads 0x01 to 0x12. A write with wr_en while run_en is high stores the BCD value of wr_data, and the field reads back that value from the next cycle on.
- R9: The year is three BCD digits: tens and units in bits [7:0], hundreds in bits [11:8]. The carry from 199 reads as 0x200.
- R10: A write while run_en is low changes no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle enable from the slow base clock |
| run_en | input | 1 | Run enable: counts time and permits writes |
| wr_en | input | 1 | Write strobe for the selected field |
| wr_sel | input | 3 | Field select for writes |
| wr_data | input | 12 | BCD write value |
| rd_sel | input | 3 | Field select for reads |
| rd_data | output | 12 | BCD value of the selected field |
| sec_strobe | output | 1 | High for one cycle when a new second is readable |

## Verification
A write becomes readable one cycle after the edge that takes it. The read path has no register, so the bench sets rd_sel and samples rd_data within the same low half of the clock. The second step lands on the edge that counts the TICKS_PER_SEC-th tick, so the bench checks one tick earlier that nothing has moved, then checks the full set of fields and the strobe right after the step, and checks one cycle later that the strobe has dropped. Inputs change on falling edges and results are sampled there, one register delay after the edge being checked.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int SEC_W     = 6;
    localparam int MIN_W     = 6;
    localparam int HOUR_W    = 5;
    localparam int MDAY_W    = 5;
    localparam int WDAY_W    = 3;
    localparam int MON_W     = 4;
    localparam int YEAR_W    = 10;
    localparam int YEAR_SPAN = 1000;
    localparam int DATA_W    = 12;

    typedef enum logic [2:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_MDAY = 3'd3,
        SEL_WDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6,
        SEL_NONE = 3'd7
    } field_sel_e;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [MDAY_W-1:0] mday;
        logic [WDAY_W-1:0] wday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  mins;
        logic [SEC_W-1:0]  sec;
    } cal_time_t;

    // two BCD digits to binary (0..165 for any byte)
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return 8'({4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]});
    endfunction

    // binary 0..99 to two BCD digits
    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v % 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic leap_year(input logic [YEAR_W-1:0] y, input int base);
        int full;
        full = int'(y) + base;
        return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
    endfunction

    // month is 0-based internally; unknown codes get 31 days
    function automatic logic [4:0] month_days(input logic [MON_W-1:0] m, input logic leap);
        logic [4:0] d;
        case (m)
            4'd1:                  d = leap ? 5'd29 : 5'd28;
            4'd3, 4'd5, 4'd8, 4'd10: d = 5'd30;
            default:               d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
    parameter int TICKS = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    input  logic base_tick,
    output logic adv,
    output logic strobe
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign adv = run_en && base_tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt <= '0;
        end else if (base_tick) begin
            cnt <= adv ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe <= 1'b0;
        end else begin
            strobe <= adv;
        end
    end

endmodule

// File: rtl/rtc_cal_fields.sv
module rtc_cal_fields
    import rtc_cal_pkg::*;
#(
    parameter int YEAR_BASE = 1900
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              wr_ok,
    input  field_sel_e        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cal_time_t         cur
);
    localparam cal_time_t RESET_TIME = '{year: '0, mon: '0, mday: MDAY_W'(1),
                                         wday: '0, hour: '0, mins: '0, sec: '0};

    cal_time_t          nxt;
    logic [SEC_W:0]     sec_inc;
    logic [MIN_W:0]     min_inc;
    logic [HOUR_W:0]    hour_inc;
    logic [WDAY_W:0]    wday_inc;
    logic [MDAY_W:0]    day_inc;
    logic [MON_W:0]     mon_inc;
    logic [YEAR_W:0]    year_inc;
    logic [4:0]         dim;
    logic               c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0]         wr_bin;
    logic [7:0]         wr_mon;
    logic [11:0]        wr_year;

    always_comb begin
        sec_inc  = {1'b0, cur.sec} + 1'b1;
        min_inc  = {1'b0, cur.mins} + 1'b1;
        hour_inc = {1'b0, cur.hour} + 1'b1;
        wday_inc = {1'b0, cur.wday} + 1'b1;
        day_inc  = {1'b0, cur.mday} + 1'b1;
        mon_inc  = {1'b0, cur.mon} + 1'b1;
        year_inc = {1'b0, cur.year} + 1'b1;
        dim      = month_days(cur.mon, leap_year(cur.year, YEAR_BASE));

        c_min  = adv    && (sec_inc  >= (SEC_W+1)'(60));
        c_hour = c_min  && (min_inc  >= (MIN_W+1)'(60));
        c_day  = c_hour && (hour_inc >= (HOUR_W+1)'(24));
        c_mon  = c_day  && (day_inc  >  {1'b0, dim});
        c_year = c_mon  && (mon_inc  >= (MON_W+1)'(12));

        nxt = cur;
        if (adv)    nxt.sec  = c_min  ? '0 : sec_inc[SEC_W-1:0];
        if (c_min)  nxt.mins = c_hour ? '0 : min_inc[MIN_W-1:0];
        if (c_hour) nxt.hour = c_day  ? '0 : hour_inc[HOUR_W-1:0];
        if (c_day) begin
            nxt.wday = (wday_inc >= (WDAY_W+1)'(7)) ? '0 : wday_inc[WDAY_W-1:0];
            nxt.mday = c_mon ? MDAY_W'(1) : day_inc[MDAY_W-1:0];
        end
        if (c_mon)  nxt.mon  = c_year ? '0 : mon_inc[MON_W-1:0];
        if (c_year) nxt.year = (year_inc >= (YEAR_W+1)'(YEAR_SPAN)) ? '0 : year_inc[YEAR_W-1:0];

        // an accepted write overrides the selected field only
        wr_bin  = bcd_to_bin(wr_data[7:0]);
        wr_mon  = wr_bin - 8'd1;
        wr_year = 12'(wr_bin) + 12'(wr_data[11:8]) * 12'd100;
        if (wr_ok) begin
            case (wr_sel)
                SEL_SEC:  nxt.sec  = wr_bin[SEC_W-1:0];
                SEL_MIN:  nxt.mins = wr_bin[MIN_W-1:0];
                SEL_HOUR: nxt.hour = wr_bin[HOUR_W-1:0];
                SEL_MDAY: nxt.mday = wr_bin[MDAY_W-1:0];
                SEL_WDAY: nxt.wday = wr_bin[WDAY_W-1:0];
                SEL_MON:  nxt.mon  = wr_mon[MON_W-1:0];
                SEL_YEAR: nxt.year = wr_year[YEAR_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= RESET_TIME;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/rtc_bcd_readout.sv
module rtc_bcd_readout
    import rtc_cal_pkg::*;
(
    input  cal_time_t         cur,
    input  field_sel_e        sel,
    output logic [DATA_W-1:0] data
);
    logic [6:0] y_lo;
    logic [3:0] y_hi;

    always_comb begin
        y_lo = 7'(cur.year % YEAR_W'(100));
        y_hi = 4'(cur.year / YEAR_W'(100));
        case (sel)
            SEL_SEC:  data = {4'h0, bin_to_bcd(7'(cur.sec))};
            SEL_MIN:  data = {4'h0, bin_to_bcd(7'(cur.mins))};
            SEL_HOUR: data = {4'h0, bin_to_bcd(7'(cur.hour))};
            SEL_MDAY: data = {4'h0, bin_to_bcd(7'(cur.mday))};
            SEL_WDAY: data = {4'h0, bin_to_bcd(7'(cur.wday))};
            SEL_MON:  data = {4'h0, bin_to_bcd(7'(cur.mon) + 7'd1)};
            SEL_YEAR: data = {y_hi, bin_to_bcd(y_lo)};
            default:  data = '0;
        endcase
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int YEAR_BASE     = 1900
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        base_tick,
    input  logic        run_en,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [11:0] rd_data,
    output logic        sec_strobe
);
    cal_time_t cur_time;
    logic      adv;

    rtc_sec_prescaler #(.TICKS(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .base_tick (base_tick),
        .adv       (adv),
        .strobe    (sec_strobe)
    );

    rtc_cal_fields #(.YEAR_BASE(YEAR_BASE)) u_fields (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .wr_ok   (wr_en && run_en),
        .wr_sel  (field_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .cur     (cur_time)
    );

    rtc_bcd_readout u_read (
        .cur  (cur_time),
        .sel  (field_sel_e'(rd_sel)),
        .data (rd_data)
    );

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
    import rtc_cal_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      run_en,
    input logic      base_tick,
    input logic      wr_en,
    input logic      sec_strobe,
    input cal_time_t cur_time
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sec_strobe |=> !sec_strobe); // R2

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        sec_strobe |-> $past(run_en && base_tick)); // R3

    AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en && run_en) && !sec_strobe) |-> $stable(cur_time)); // R10

    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        (sec_strobe && !$past(wr_en && run_en) && (cur_time.mins != $past(cur_time.mins)))
        |-> (cur_time.sec == '0)); // R4

    AST_DAY_AT_MIDNIGHT: assert property (@(posedge clk) disable iff (rst)
        (sec_strobe && !$past(wr_en && run_en) && (cur_time.mday != $past(cur_time.mday)))
        |-> (cur_time.hour == '0 && cur_time.mins == '0 && cur_time.sec == '0)); // R5

    AST_YEAR_AT_NEWYEAR: assert property (@(posedge clk) disable iff (rst)
        (sec_strobe && !$past(wr_en && run_en) && (cur_time.year != $past(cur_time.year)))
        |-> (cur_time.mon == '0 && cur_time.mday == MDAY_W'(1))); // R6

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .base_tick  (base_tick),
    .wr_en      (wr_en),
    .sec_strobe (sec_strobe),
    .cur_time   (cur_time)
);

// File: tb/rtc_calendar_core_tb.sv
`timescale 1ns/1ps
module rtc_calendar_core_tb;

    localparam int BT = 16;

    typedef struct packed {
        logic [7:0]  sec, mins, hour, mday, wday, mon;
        logic [11:0] year;
    } bcd_t;

    typedef struct packed {
        bcd_t       pre;
        bcd_t       exp;
        logic [3:0] req;
    } vec_t;

    // fields: sec, min, hour, day, weekday, month, year
    localparam vec_t VECS [13] = '{
        '{'{8'h05,8'h00,8'h00,8'h01,8'h00,8'h01,12'h000}, '{8'h06,8'h00,8'h00,8'h01,8'h00,8'h01,12'h000}, 4'd8}, // R8
        '{'{8'h59,8'h12,8'h07,8'h09,8'h03,8'h06,12'h045}, '{8'h00,8'h13,8'h07,8'h09,8'h03,8'h06,12'h045}, 4'd4}, // R4
        '{'{8'h59,8'h59,8'h09,8'h09,8'h03,8'h06,12'h045}, '{8'h00,8'h00,8'h10,8'h09,8'h03,8'h06,12'h045}, 4'd4}, // R4
        '{'{8'h59,8'h59,8'h23,8'h15,8'h06,8'h03,12'h123}, '{8'h00,8'h00,8'h00,8'h16,8'h00,8'h03,12'h123}, 4'd5}, // R5
        '{'{8'h59,8'h59,8'h23,8'h30,8'h02,8'h04,12'h123}, '{8'h00,8'h00,8'h00,8'h01,8'h03,8'h05,12'h123}, 4'd6}, // R6
        '{'{8'h59,8'h59,8'h23,8'h31,8'h01,8'h12,12'h199}, '{8'h00,8'h00,8'h00,8'h01,8'h02,8'h01,12'h200}, 4'd9}, // R9
        '{'{8'h59,8'h59,8'h23,8'h28,8'h04,8'h02,12'h101}, '{8'h00,8'h00,8'h00,8'h01,8'h05,8'h03,12'h101}, 4'd7}, // R7
        '{'{8'h59,8'h59,8'h23,8'h28,8'h04,8'h02,12'h104}, '{8'h00,8'h00,8'h00,8'h29,8'h05,8'h02,12'h104}, 4'd7}, // R7
        '{'{8'h59,8'h59,8'h23,8'h28,8'h04,8'h02,12'h100}, '{8'h00,8'h00,8'h00,8'h29,8'h05,8'h02,12'h100}, 4'd7}, // R7
        '{'{8'h59,8'h59,8'h23,8'h28,8'h04,8'h02,12'h200}, '{8'h00,8'h00,8'h00,8'h01,8'h05,8'h03,12'h200}, 4'd7}, // R7
        '{'{8'h59,8'h59,8'h23,8'h29,8'h02,8'h02,12'h104}, '{8'h00,8'h00,8'h00,8'h01,8'h03,8'h03,12'h104}, 4'd7}, // R7
        '{'{8'h59,8'h59,8'h23,8'h31,8'h05,8'h12,12'h999}, '{8'h00,8'h00,8'h00,8'h01,8'h06,8'h01,12'h000}, 4'd6}, // R6
        '{'{8'h59,8'h59,8'h23,8'h31,8'h00,8'h01,12'h050}, '{8'h00,8'h00,8'h00,8'h01,8'h01,8'h02,12'h050}, 4'd6}  // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_tick = 1'b0;
    logic        run_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [11:0] rd_data;
    logic        sec_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rtc_calendar_core #(.TICKS_PER_SEC(BT), .YEAR_BASE(1900)) u_dut (
        .clk(clk), .rst(rst), .base_tick(base_tick), .run_en(run_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .sec_strobe(sec_strobe)
    );

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [11:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [11:0] d);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_all(input string tag, input bcd_t e);
        logic [11:0] v;
        rd(3'd0, v); chk({tag, " sec"},  v, {4'h0, e.sec});
        rd(3'd1, v); chk({tag, " min"},  v, {4'h0, e.mins});
        rd(3'd2, v); chk({tag, " hour"}, v, {4'h0, e.hour});
        rd(3'd3, v); chk({tag, " day"},  v, {4'h0, e.mday});
        rd(3'd4, v); chk({tag, " wday"}, v, {4'h0, e.wday});
        rd(3'd5, v); chk({tag, " mon"},  v, {4'h0, e.mon});
        rd(3'd6, v); chk({tag, " year"}, v, e.year);
    endtask

    task automatic restart_run();
        run_en = 1'b0;
        base_tick = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [11:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_all("R1 reset", '{8'h00,8'h00,8'h00,8'h01,8'h00,8'h01,12'h000});
        chk("R1 strobe", {11'd0, sec_strobe}, 12'd0);
        rd(3'd7, v); chk("R8 sel7 reads zero", v, 12'h000);

        foreach (VECS[i]) begin
            restart_run();
            wr(3'd0, {4'h0, VECS[i].pre.sec});
            wr(3'd1, {4'h0, VECS[i].pre.mins});
            wr(3'd2, {4'h0, VECS[i].pre.hour});
            wr(3'd3, {4'h0, VECS[i].pre.mday});
            wr(3'd4, {4'h0, VECS[i].pre.wday});
            wr(3'd5, {4'h0, VECS[i].pre.mon});
            wr(3'd6, VECS[i].pre.year);
            base_tick = 1'b1;
            repeat (BT - 1) @(negedge clk);
            // R2: one tick short, nothing moved yet
            rd(3'd0, v);
            chk($sformatf("R2 vec%0d early sec", i), v, {4'h0, VECS[i].pre.sec});
            chk($sformatf("R2 vec%0d early strobe", i), {11'd0, sec_strobe}, 12'd0);
            @(negedge clk);
            base_tick = 1'b0;
            chk($sformatf("R2 vec%0d strobe", i), {11'd0, sec_strobe}, 12'd1);
            chk_all($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
            @(negedge clk);
            chk($sformatf("R2 vec%0d strobe drop", i), {11'd0, sec_strobe}, 12'd0);
        end

        // R10 writes ignored while stopped (last state: 00:00:00, day 01, month 02)
        run_en = 1'b0;
        wr(3'd0, 12'h042);
        wr(3'd5, 12'h007);
        rd(3'd0, v); chk("R10 sec kept", v, 12'h000);
        rd(3'd5, v); chk("R10 mon kept", v, 12'h002);

        // R8 / R9 write readback while running
        restart_run();
        wr(3'd5, 12'h011);
        wr(3'd6, 12'h987);
        rd(3'd5, v); chk("R8 mon readback", v, 12'h011);
        rd(3'd6, v); chk("R9 year readback", v, 12'h987);

        // R3 ticks with gaps: only high cycles count
        restart_run();
        wr(3'd0, 12'h010);
        for (int i = 0; i < BT; i++) begin
            base_tick = 1'b1;
            @(negedge clk);
            base_tick = 1'b0;
            if (i == BT - 2) begin
                rd(3'd0, v); chk("R3 gapped early", v, 12'h010);
            end
            if (i == BT - 1) begin
                rd(3'd0, v); chk("R3 gapped step", v, 12'h011);
                chk("R3 gapped strobe", {11'd0, sec_strobe}, 12'd1);
            end
            @(negedge clk);
        end

        // R3 no time passes while stopped
        run_en = 1'b0;
        base_tick = 1'b1;
        repeat (3 * BT) @(negedge clk);
        rd(3'd0, v); chk("R3 stopped sec", v, 12'h011);

        // R2 dropping run_en clears the partial count
        restart_run();
        wr(3'd0, 12'h020);
        base_tick = 1'b1;
        repeat (BT / 2) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        repeat (BT - 1) @(negedge clk);
        rd(3'd0, v); chk("R2 restart early", v, 12'h020);
        @(negedge clk);
        base_tick = 1'b0;
        rd(3'd0, v); chk("R2 restart step", v, 12'h021);

        finish_run();
    end

endmodule